// File: doc/BRIEF.md
# Timer Match Action Controller

This block is a 16-bit timer built from a prescale counter and a main timer count. The prescale counter runs while the run bit is set. Each time it reaches the programmed prescale limit it returns to zero and advances the timer count by one. That cycle is called a tick. Ten match channels watch the timer count. Each channel holds a compare value and three action bits: raise an interrupt flag, zero the count, or halt the timer and drop the run bit.

Software drives the block through a simple single-cycle register port. A write lands on the next clock edge, and a read is combinational. The register map is: 0x00 control (bit 0 run, bit 1 counter clear, which is write-only and self-clearing), 0x04 interrupt flags (write 1 to clear), 0x08 timer count (read-only), 0x0C prescale limit, 0x10 prescale count (read-only), 0x14 match action word, and 0x18 + 4·k the compare value of channel k. A three-bit counting-mode input qualifies the interrupts. Only the up-counting code 0 lets match flags be set.

Top module: `tmr_match_ctrl`

## Requirements
- R1: After reset the run bit, prescale limit, action word, compare values, both counters and all flags are 0, and irq is 0. Every register reads back 0.
- R2: While run is 1, the prescale count steps up once per clock until it is at or above the limit. On that cycle (a tick) it returns to 0 and the timer count rises by one, so the count advances once every limit+1 clocks. While run is 0 both counters hold.
- R3: In the action word, channel k uses bit 3k for interrupt, bit 3k+1 for zero-count and bit 3k+2 for halt. A bit value of 1 enables the action and 0 disables it. The word reads back as written, over its low 30 bits.
- R4: On a tick where the timer count equals the compare value of a channel whose zero-count bit is set, and no halt applies, the count becomes 0. A compare value N therefore gives a repeating cycle 0..N of N+1 ticks.
- R5: On a tick where the count equals the compare value of a channel whose halt bit is set, the run bit clears, the timer count keeps its value and the prescale count is 0. This also applies when a run write lands on the same edge.
- R6: When halt and zero-count matches occur on the same tick, the halt wins and the count is not zeroed.
- R7: On a tick with counting mode 0, every channel whose count matches and whose interrupt bit is set raises its flag. Several flags can be raised on the same tick.
- R8: With counting mode other than 0, no flag is raised, but counting and the other match actions proceed.
- R9: Flags stay set until a 1 is written to their bit at 0x04. A flag that is raised on the same edge as its clear stays set.
- R10: irq is 1 exactly when at least one flag is set.
- R11: Writing bit 1 of the control register zeroes both counters on that edge and suppresses that cycle's tick. The run bit takes bit 0 of the same write.
- R12: A matching channel whose three action bits are all 0 has no effect on counting, the run bit or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte address |
| rd_data | output | 32 | Register read data (combinational) |
| cnt_mode | input | 3 | Counting mode; 0 selects up-counting |
| run | output | 1 | Current run bit |
| tc_value | output | 16 | Current timer count |
| match_irq | output | 10 | Per-channel sticky interrupt flags |
| irq | output | 1 | OR of all flags |

## Verification
On every cycle, the in-RTL assertions check these properties:
- A prescale wrap returns the prescale count to zero, and the count otherwise steps by one.
- The timer count is still between ticks.
- A halt drops run and freezes the count, even when a zero-count match happens at the same time.
- A zero-count match yields zero.
- Flags never rise outside mode 0 and never fall without a clear write.

Some behaviour needs the bench's scenarios, which compare against a behavioural model on every clock: the exact tick period for a given limit, the N+1 length of a wrapping cycle, the register layout and readback, several flags rising together, and a flag raise beating its own clear on the same edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_CTRL = 'h00;
  localparam int ADDR_FLAG = 'h04;
  localparam int ADDR_TC   = 'h08;
  localparam int ADDR_PRE  = 'h0C;
  localparam int ADDR_PC   = 'h10;
  localparam int ADDR_MCTL = 'h14;
  localparam int ADDR_MR0  = 'h18;

  // action bit offsets inside a channel's 3-bit slice
  localparam int ACT_INT  = 0;
  localparam int ACT_ZERO = 1;
  localparam int ACT_HALT = 2;

  localparam logic [2:0] CM_UP = 3'd0;

  function automatic int mr_addr(int k);
    return ADDR_MR0 + 4 * k;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          clear,
  input  logic [TW-1:0] limit,
  output logic [TW-1:0] pc_o,
  output logic          tick_o
);
  logic [TW-1:0] pc_q;

  assign tick_o = run && (pc_q >= limit) && !clear;
  assign pc_o   = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (clear)   pc_q <= '0;
    else if (tick_o)  pc_q <= '0;
    else if (run)     pc_q <= pc_q + 1'b1;
  end

  // R2: a wrap always returns to zero
  a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> pc_q == '0);
  // R2: between wraps the prescale count steps by exactly one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_o && !clear) |=> pc_q == TW'($past(pc_q) + 1'b1));
endmodule

// File: rtl/tmr_match_bank.sv
module tmr_match_bank #(
  parameter int NCH = 10,
  parameter int TW  = 16,
  localparam int MCW = 3 * NCH
) (
  input  logic [TW-1:0]          tc,
  input  logic [NCH-1:0][TW-1:0] mr,
  input  logic [MCW-1:0]         mctl,
  output logic [NCH-1:0]         hit_int,
  output logic                   any_halt,
  output logic                   any_zero
);
  import tmr_pkg::*;

  logic [NCH-1:0] eq, halt_v, zero_v;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign eq[k]      = (mr[k] == tc);
    assign hit_int[k] = eq[k] & mctl[3*k + ACT_INT];
    assign zero_v[k]  = eq[k] & mctl[3*k + ACT_ZERO];
    assign halt_v[k]  = eq[k] & mctl[3*k + ACT_HALT];
  end

  assign any_halt = |halt_v;
  assign any_zero = |zero_v;
endmodule

// File: rtl/tmr_match_ctrl.sv
module tmr_match_ctrl #(
  parameter int NCH = 10,
  parameter int TW  = 16,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [2:0]     cnt_mode,
  output logic           run,
  output logic [TW-1:0]  tc_value,
  output logic [NCH-1:0] match_irq,
  output logic           irq
);
  import tmr_pkg::*;

  localparam int MCW = 3 * NCH;

  logic                   cen_q;
  logic [TW-1:0]          pre_q, tc_q, pc;
  logic [MCW-1:0]         mctl_q;
  logic [NCH-1:0][TW-1:0] mr_q;
  logic [NCH-1:0]         flags_q, hit_int, flag_set, flag_clr;
  logic                   any_halt, any_zero, tick;
  logic                   wr_ctrl, clr_req, halt_evt, zero_evt;
  logic                   unused_hi;

  function automatic logic [TW-1:0] tc_after_tick(logic [TW-1:0] cur,
                                                  logic halt, logic zero);
    if (halt)      return cur;
    else if (zero) return '0;
    else           return cur + 1'b1;
  endfunction

  assign unused_hi = ^wr_data[DW-1:MCW];

  assign wr_ctrl  = wr_en && (wr_addr == AW'(ADDR_CTRL));
  assign clr_req  = wr_ctrl && wr_data[1];
  assign flag_clr = (wr_en && wr_addr == AW'(ADDR_FLAG)) ? wr_data[NCH-1:0] : '0;

  tmr_prescaler #(.TW(TW)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(cen_q), .clear(clr_req),
    .limit(pre_q), .pc_o(pc), .tick_o(tick)
  );

  tmr_match_bank #(.NCH(NCH), .TW(TW)) u_bank (
    .tc(tc_q), .mr(mr_q), .mctl(mctl_q),
    .hit_int(hit_int), .any_halt(any_halt), .any_zero(any_zero)
  );

  assign halt_evt = tick && any_halt;
  assign zero_evt = tick && any_zero && !any_halt;
  assign flag_set = (tick && cnt_mode == CM_UP) ? hit_int : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen_q  <= 1'b0;
      pre_q  <= '0;
      mctl_q <= '0;
      tc_q   <= '0;
      flags_q <= '0;
      mr_q   <= '0;
    end else begin
      if (halt_evt)     cen_q <= 1'b0;
      else if (wr_ctrl) cen_q <= wr_data[0];

      if (clr_req)   tc_q <= '0;
      else if (tick) tc_q <= tc_after_tick(tc_q, any_halt, any_zero);

      flags_q <= (flags_q & ~flag_clr) | flag_set;

      if (wr_en && wr_addr == AW'(ADDR_PRE))  pre_q  <= wr_data[TW-1:0];
      if (wr_en && wr_addr == AW'(ADDR_MCTL)) mctl_q <= wr_data[MCW-1:0];
      for (int k = 0; k < NCH; k++)
        if (wr_en && wr_addr == AW'(mr_addr(k))) mr_q[k] <= wr_data[TW-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(ADDR_CTRL): rd_data = DW'(cen_q);
      AW'(ADDR_FLAG): rd_data = DW'(flags_q);
      AW'(ADDR_TC):   rd_data = DW'(tc_q);
      AW'(ADDR_PRE):  rd_data = DW'(pre_q);
      AW'(ADDR_PC):   rd_data = DW'(pc);
      AW'(ADDR_MCTL): rd_data = DW'(mctl_q);
      default: begin
        for (int k = 0; k < NCH; k++)
          if (rd_addr == AW'(mr_addr(k))) rd_data = DW'(mr_q[k]);
      end
    endcase
  end

  assign run       = cen_q;
  assign tc_value  = tc_q;
  assign match_irq = flags_q;
  assign irq       = |flags_q;

  // R5: a halt match drops run and freezes the count
  a_r5_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    halt_evt |=> (!cen_q && tc_q == $past(tc_q)));
  // R6: halt beats zero-count on the same tick
  a_r6_halt_over_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && any_halt && any_zero) |=> tc_q == $past(tc_q));
  // R4: zero-count match clears the count
  a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> tc_q == '0);
  // R2: count rises by one on a plain tick
  a_r2_tc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !any_halt && !any_zero) |=> tc_q == TW'($past(tc_q) + 1'b1));
  // R2: count holds between ticks
  a_r2_tc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr_req) |=> $stable(tc_q));
  // R8: no flag rises outside up-counting mode
  a_r8_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_mode != CM_UP) |=> ((flags_q & ~$past(flags_q)) == '0));
  // R9: flags fall only through a clear write
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == AW'(ADDR_FLAG)) |=> (($past(flags_q) & ~flags_q) == '0));
  // R11: counter clear zeroes the count
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> tc_q == '0);
endmodule

// File: tb/sim_tmr_match_ctrl.sv
`timescale 1ns/1ps
module sim_tmr_match_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  cnt_mode = '0;
  logic        run;
  logic [15:0] tc_value;
  logic [9:0]  match_irq;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tmr_match_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_mode(cnt_mode), .run(run), .tc_value(tc_value),
    .match_irq(match_irq), .irq(irq)
  );

  // behavioural reference model
  int m_cen, m_pc, m_tc, m_flags, m_pre, m_mc;
  int m_mr[10];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cen = 0; m_pc = 0; m_tc = 0; m_flags = 0; m_pre = 0; m_mc = 0;
      foreach (m_mr[i]) m_mr[i] = 0;
    end else begin
      bit clr, tk, st, zr;
      int ints, w1c, n_cen;
      clr = wr_en && wr_addr == 8'h00 && wr_data[1];
      tk  = (m_cen != 0) && m_pc >= m_pre && !clr;
      st = 0; zr = 0; ints = 0;
      for (int k = 0; k < 10; k++) begin
        if (m_mr[k] == m_tc) begin
          if ((m_mc >> (3*k)) & 1)     ints |= (1 << k);
          if ((m_mc >> (3*k + 1)) & 1) zr = 1;
          if ((m_mc >> (3*k + 2)) & 1) st = 1;
        end
      end
      if (tk && st) n_cen = 0;
      else if (wr_en && wr_addr == 8'h00) n_cen = wr_data[0];
      else n_cen = m_cen;
      if (clr) begin
        m_tc = 0; m_pc = 0;
      end else if (tk) begin
        m_pc = 0;
        if (!st) m_tc = zr ? 0 : ((m_tc + 1) & 16'hFFFF);
      end else if (m_cen != 0) begin
        m_pc = m_pc + 1;
      end
      w1c = (wr_en && wr_addr == 8'h04) ? int'(wr_data[9:0]) : 0;
      m_flags = (m_flags & ~w1c) | ((tk && cnt_mode == 3'd0) ? ints : 0);
      m_cen = n_cen;
      if (wr_en && wr_addr == 8'h0C) m_pre = int'(wr_data[15:0]);
      if (wr_en && wr_addr == 8'h14) m_mc = int'(wr_data[29:0]);
      for (int k = 0; k < 10; k++)
        if (wr_en && wr_addr == 8'(8'h18 + 4*k)) m_mr[k] = int'(wr_data[15:0]);
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 timer count", int'(tc_value), m_tc);
      chk("R5 run bit", int'(run), m_cen);
      chk("R7 flags", int'(match_irq), m_flags);
      chk("R10 irq", int'(irq), (m_flags != 0) ? 1 : 0);
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      'h00: return m_cen;
      'h04: return m_flags;
      'h08: return m_tc;
      'h0C: return m_pre;
      'h10: return m_pc;
      'h14: return m_mc;
      default: begin
        for (int k = 0; k < 10; k++) if (a == 'h18 + 4*k) return m_mr[k];
        return 0;
      end
    endcase
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a);
    @(negedge clk);
    rd_addr = 8'(a);
    #1;
    chk(tag, int'(rd_data), exp_rd(a));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic halt_and_clear();
    wr('h00, 2);   // run=0, clear counters
  endtask

  initial begin
    int mx, n;
    logic [15:0] prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and of irq
    for (int a = 0; a < 'h18 + 40; a += 4) begin
      @(negedge clk); rd_addr = 8'(a); #1;
      chk("R1 reset readback", int'(rd_data), 0);
    end
    chk("R1 irq after reset", int'(irq), 0);

    // R2: limit 3 gives a tick every 4 clocks
    wr('h0C, 3);
    wr('h00, 1);
    prev = tc_value;
    while (tc_value == prev) @(negedge clk);
    prev = tc_value; n = 0;
    while (tc_value == prev) begin @(negedge clk); n++; end
    chk("R2 tick period", n, 4);
    rd_chk("R2 prescale count readback", 'h10);

    // R4: zero-count on channel 3 at 5
    halt_and_clear();
    wr('h0C, 0);
    wr('h18 + 12, 5);
    wr('h14, 1 << 10);
    rd_chk("R3 action word readback", 'h14);
    wr('h00, 1);
    mx = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(tc_value) > mx) mx = int'(tc_value);
    end
    chk("R4 count never exceeds match", mx, 5);
    while (tc_value != 0) @(negedge clk);
    n = 0;
    do begin @(negedge clk); n++; end while (tc_value != 0);
    chk("R4 cycle length N+1", n, 6);

    // R7/R3: channels 0 and 7 interrupt together at 4
    halt_and_clear();
    wr('h18, 4);
    wr('h18 + 28, 4);
    wr('h14, 1 | (1 << 21));
    wr('h00, 1);
    idle(10);
    chk("R7 two flags raised together", int'(match_irq), 'h81);
    chk("R10 irq with flags", int'(irq), 1);
    rd_chk("R3 flag register readback", 'h04);

    // R9: sticky, write-1-clear
    wr('h04, 1);
    chk("R9 clear only bit 0", int'(match_irq), 'h80);
    idle(5);
    chk("R9 flag stays set", int'(match_irq), 'h80);
    wr('h04, 'h80);
    chk("R9 all flags cleared", int'(match_irq), 0);
    chk("R10 irq low with no flags", int'(irq), 0);

    // R8: other counting mode suppresses flags, counting goes on
    halt_and_clear();
    cnt_mode = 3'd3;
    wr('h00, 1);
    idle(10);
    chk("R8 no flags outside mode 0", int'(match_irq), 0);
    chk("R8 counting continues", (tc_value > 4) ? 1 : 0, 1);
    cnt_mode = 3'd0;

    // R5/R6: halt on channel 9 and zero on channel 2, both at 7
    halt_and_clear();
    wr('h0C, 1);
    wr('h18 + 36, 7);
    wr('h18 + 8, 7);
    wr('h14, (1 << 29) | (1 << 7));
    wr('h00, 1);
    idle(40);
    chk("R5 run dropped", int'(run), 0);
    chk("R6 count held at match", int'(tc_value), 7);
    rd_chk("R5 prescale count zero", 'h10);
    rd_chk("R5 control reads run clear", 'h00);

    // R11: clear with run
    wr('h00, 3);
    chk("R11 count zero after clear", int'(tc_value), 0);
    chk("R11 run taken from bit 0", int'(run), 1);
    halt_and_clear();
    rd_chk("R11 prescale zero after clear", 'h10);

    // R12: matching channel with no actions
    wr('h14, 0);
    wr('h0C, 0);
    wr('h18 + 4, 3);
    wr('h00, 1);
    idle(10);
    chk("R12 no flags", int'(match_irq), 0);
    chk("R12 still running", int'(run), 1);
    chk("R12 count passed match", (tc_value > 3) ? 1 : 0, 1);

    // R9: raise and clear on the same edge, raise wins
    halt_and_clear();
    wr('h18, 20);
    wr('h14, 1);
    wr('h00, 1);
    while (tc_value != 20) @(negedge clk);
    wr_en = 1'b1; wr_addr = 8'h04; wr_data = 32'd1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 raise beats same-edge clear", int'(match_irq[0]), 1);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule